// File: doc/BRIEF.md
# Wide-Vector Dispatch Throttle Controller

This block gates instruction dispatch in a core that carries a power-hungry wide vector unit. It tracks whether wide vector work is being dispatched or is waiting in the scheduler, and how long the core has gone without any. When wide work shows up while the core sits in its low-power state, the controller cuts dispatch for every instruction class to one cycle in four. At the same moment it raises a request for a voltage and frequency transition.

The throttle stays in force only while both of these hold: a wide operation sits in the scheduler, and the power manager has not yet acknowledged the transition. Once the acknowledge arrives, dispatch returns to every cycle. The block then reports that the core runs at a reduced clock, and it stays in this settled wide state until a programmable number of consecutive cycles pass with no wide activity. At that point it drops back to the low-power state.

The regulator, the clock generator and the scheduler are outside the block. It only sees their per-cycle flags and drives three per-cycle outputs.

Top module: `vec_throttle_ctrl`

## Requirements
- R1: After reset the controller is in the low-power state: `dispatch_en_o`=1, `pwr_req_o`=0, `low_freq_o`=0.
- R2: In the low-power state, a cycle with `wide_disp_i` or `wide_in_sched_i` high moves the controller to the throttled state on the next cycle. The throttled state is visible as `pwr_req_o`=1.
- R3: In the throttled state with `wide_in_sched_i`=1, `dispatch_en_o` is 1 on the entry cycle and on every fourth cycle after it, and 0 on the other cycles. The phase restarts from zero on every entry. `dispatch_en_o` is the one enable shared by all instruction classes.
- R4: In the throttled state, a cycle with `wide_in_sched_i`=0 has `dispatch_en_o`=1 while `pwr_req_o` stays 1. The four-cycle phase keeps advancing across such cycles.
- R5: `pwr_req_o` stays 1 until a cycle with `pwr_ack_i`=1. On the cycle after that acknowledge, `pwr_req_o`=0 and `low_freq_o`=1.
- R6: In the settled wide state, `dispatch_en_o`=1 on every cycle and `low_freq_o`=1. `low_freq_o` and `pwr_req_o` are never 1 together.
- R7: In the settled wide state, after N consecutive cycles with both wide flags low, the next cycle is in the low-power state (`low_freq_o`=0). N is `idle_limit_i`, and a value of 0 counts as 1. Any wide flag restarts the count.
- R8: `pwr_ack_i` has no effect outside the throttled state.
- R9: Wide activity in the settled wide state causes no throttling and no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_disp_i | input | 1 | A wide vector operation is dispatched this cycle |
| wide_in_sched_i | input | 1 | A wide vector operation is present in the scheduler |
| idle_limit_i | input | IDLE_W | Quiet cycles before returning to low power (0 acts as 1) |
| pwr_ack_i | input | 1 | Power manager has completed the transition |
| dispatch_en_o | output | 1 | Dispatch allowed this cycle, all instruction classes |
| pwr_req_o | output | 1 | Voltage and frequency transition requested |
| low_freq_o | output | 1 | Core is in the settled wide state at reduced clock |

## Verification
The bench checks the throttle duty on a long throttled stretch. It looks for the allowed slot on the entry cycle and a gap of exactly three cycles after it. A phase counter that was not cleared on entry would open its slot in the wrong cycle.

Other runs interleave cycles with an empty scheduler during the throttle. A design that kept stalling would show `dispatch_en_o` low there, and one that dropped the request early would show `pwr_req_o` low.

Quiet stretches are cut one cycle short of the limit, and a limit of zero is tried. These catch an off-by-one timer, or one that is never restarted. Acknowledges arrive while idle and while settled; a design that honours them there would raise `low_freq_o` or leave the settled state.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_LOW    = 2'd0,
        ST_THROTTLED   = 2'd1,
        ST_WIDE_ACTIVE = 2'd2
    } vt_state_e;

    typedef struct packed {
        vt_state_e state;
    } vt_fsm_reg_t;

endpackage

// File: rtl/vt_idle_timer.sv
module vt_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             quiet_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t   r_d, r_q;
    logic [CNT_W:0] eff_limit;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        r_d       = r_q;
        expire_o  = 1'b0;
        eff_limit = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
        cnt_inc   = {1'b0, r_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (!run_i || !quiet_i) begin
            r_d.cnt = '0;
        end else if (cnt_inc >= eff_limit) begin
            expire_o = 1'b1;
            r_d.cnt  = '0;
        end else begin
            r_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_EXPIRE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (run_i && quiet_i)); // R7

endmodule

// File: rtl/vt_duty_gen.sv
module vt_duty_gen #(
    parameter int DUTY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic slot_o
);
    localparam int PH_W = (DUTY > 2) ? $clog2(DUTY) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DUTY - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } duty_reg_t;

    duty_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!hold_i)                 r_d.phase = '0;
        else if (r_q.phase == PH_LAST) r_d.phase = '0;
        else                         r_d.phase = r_q.phase + 1'b1;
        slot_o = (r_q.phase == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && slot_o) |=> !slot_o); // R3

endmodule

// File: rtl/vt_fsm.sv
module vt_fsm
    import vt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wide_any_i,
    input  logic      ack_i,
    input  logic      expire_i,
    output vt_state_e state_o,
    output vt_state_e state_next_o
);
    vt_fsm_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE_LOW:    if (wide_any_i) r_d.state = ST_THROTTLED;
            ST_THROTTLED:   if (ack_i)      r_d.state = ST_WIDE_ACTIVE;
            ST_WIDE_ACTIVE: if (expire_i)   r_d.state = ST_IDLE_LOW;
            default:                        r_d.state = ST_IDLE_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_IDLE_LOW};
        else        r_q <= r_d;
    end

    assign state_o      = r_q.state;
    assign state_next_o = r_d.state;

    AST_THR_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_THROTTLED && $past(r_q.state) != ST_THROTTLED)
        |-> $past(r_q.state) == ST_IDLE_LOW); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_THROTTLED && !ack_i) |=> r_q.state == ST_THROTTLED); // R5
    AST_ACK_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_THROTTLED && ack_i) |=> r_q.state == ST_WIDE_ACTIVE); // R5
    AST_LOW_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE_LOW && !wide_any_i) |=> r_q.state == ST_IDLE_LOW); // R8

endmodule

// File: rtl/vec_throttle_ctrl.sv
module vec_throttle_ctrl
    import vt_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int DUTY   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_disp_i,
    input  logic              wide_in_sched_i,
    input  logic [IDLE_W-1:0] idle_limit_i,
    input  logic              pwr_ack_i,
    output logic              dispatch_en_o,
    output logic              pwr_req_o,
    output logic              low_freq_o
);
    vt_state_e state_q, state_d;
    logic      wide_any, expire, slot, hold_thr;

    assign wide_any = wide_disp_i | wide_in_sched_i;
    assign hold_thr = (state_q == ST_THROTTLED) && (state_d == ST_THROTTLED);

    vt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_any_i   (wide_any),
        .ack_i        (pwr_ack_i),
        .expire_i     (expire),
        .state_o      (state_q),
        .state_next_o (state_d)
    );

    vt_idle_timer #(.CNT_W(IDLE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == ST_WIDE_ACTIVE),
        .quiet_i  (!wide_any),
        .limit_i  (idle_limit_i),
        .expire_o (expire)
    );

    vt_duty_gen #(.DUTY(DUTY)) u_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_thr),
        .slot_o (slot)
    );

    always_comb begin
        pwr_req_o     = (state_q == ST_THROTTLED);
        low_freq_o    = (state_q == ST_WIDE_ACTIVE);
        dispatch_en_o = !(pwr_req_o && wide_in_sched_i && !slot);
    end

    AST_STALL_ONLY_THROTTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch_en_o |-> (pwr_req_o && wide_in_sched_i)); // R4
    AST_LOWFREQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_freq_o && pwr_req_o)); // R6
    AST_SETTLED_NO_RETHROTTLE: assert property (@(posedge clk) disable iff (!rst_n)
        low_freq_o |=> !pwr_req_o); // R9

endmodule

// File: tb/tb_vec_throttle_ctrl.sv
`timescale 1ns/1ps
module tb_vec_throttle_ctrl;
    localparam int IDLE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd = 1'b0, ws = 1'b0, ack = 1'b0;
    logic [IDLE_W-1:0] lim = 16'd5;
    logic en, req, lf;

    always #2 clk = ~clk;

    vec_throttle_ctrl #(.IDLE_W(IDLE_W), .DUTY(4)) dut (
        .clk(clk), .rst_n(rst_n), .wide_disp_i(wd), .wide_in_sched_i(ws),
        .idle_limit_i(lim), .pwr_ack_i(ack),
        .dispatch_en_o(en), .pwr_req_o(req), .low_freq_o(lf)
    );

    typedef struct {
        logic  en, req, lf;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    bit done = 0;

    // requirement-level model: 0 low power, 1 throttled, 2 settled wide
    int m_mode = 0, m_ph = 0, m_quiet = 0;

    task automatic step(input logic d, input logic s, input logic a, input string tag);
        exp_t e;
        int eff;
        @(negedge clk);
        wd = d; ws = s; ack = a;
        e.en  = !(m_mode == 1 && m_ph != 0 && s);
        e.req = (m_mode == 1);
        e.lf  = (m_mode == 2);
        e.tag = tag;
        exp_q.push_back(e);
        eff = (lim == 0) ? 1 : int'(lim);
        case (m_mode)
            0: if (d || s) begin m_mode = 1; m_ph = 0; end
            1: if (a) begin m_mode = 2; m_quiet = 0; end
               else m_ph = (m_ph + 1) % 4;
            default: if (d || s) m_quiet = 0;
                     else begin
                         m_quiet++;
                         if (m_quiet >= eff) begin m_mode = 0; m_quiet = 0; end
                     end
        endcase
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (en !== e.en || req !== e.req || lf !== e.lf) begin
                    fails++;
                    $display("FAIL %s: got en=%b req=%b lf=%b expected en=%b req=%b lf=%b",
                             e.tag, en, req, lf, e.en, e.req, e.lf);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R1");
        // R8: ack while idle is ignored
        step(0, 0, 1, "R8");
        step(0, 0, 0, "R8");
        // R2: dispatch flag alone arms throttle
        step(1, 0, 0, "R2");
        // R3: scheduler holds wide op, 1-in-4 duty
        for (int i = 0; i < 10; i++) step(0, 1, 0, "R3");
        // R4: empty scheduler in throttle -> full rate, request held
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R4");
        // R5: ack completes transition
        step(0, 1, 1, "R5");
        // R6/R9: settled, wide active, full rate
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R9");
        step(0, 0, 1, "R8");
        // R7: quiet one short of limit, then restart
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R7");
        step(0, 1, 0, "R7");
        for (int i = 0; i < 7; i++) step(0, 0, 0, "R7");
        // re-arm: phase must restart from zero
        step(0, 1, 0, "R3");
        for (int i = 0; i < 6; i++) step(0, 1, 0, "R3");
        step(0, 1, 1, "R5");
        // R7: limit of zero behaves as one
        lim = '0;
        step(0, 1, 0, "R6");
        step(0, 0, 0, "R7");
        step(0, 0, 0, "R7");
        step(0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule